// File: doc/BRIEF.md
# Exception entry and dispatch controller

This block performs the state changes a processor core makes when it enters an exception or debug handler. A general exception request brings a kind, a cause code, the faulting PC and an optional faulting virtual address. In one registered step the block updates the status word, the saved-PC registers, the exception-cause register and the exception-address register. It then reports which handler vector the fetch unit must go to: user, kernel, double or debug.

A second exception raised while the exception-mode bit is still set is treated as nested. It goes to the double vector and, when so configured, its PC is kept in a separate double-exception PC register so that the first saved PC survives. A separate debug request is accepted only while the current interrupt level is below the configured debug level. Debug entry saves the complete old status word and raises the interrupt level to the debug level.

The core writes the status word through a plain load port, for example on return from a handler. The status-bit positions, the debug level, the nested-PC register option, the misalignment options and the fixed cause codes are all parameters.

Top module: `exc_dispatch_ctrl`

## Requirements
- R1: With the exception-mode bit set, a taken general exception selects vector DOUBLE (vec_sel=2). Its PC goes to depc_o when HAS_DEPC=1, leaving epc1_o unchanged. When HAS_DEPC=0 the PC goes to epc1_o and depc_o stays 0.
- R2: With the exception-mode bit clear, a taken general exception writes its PC to epc1_o. It selects USER (vec_sel=0) when the user-mode bit is set and KERNEL (vec_sel=1) otherwise.
- R3: Every taken general exception writes its cause to exccause_o and sets the exception-mode bit. vec_valid pulses for exactly one cycle, and all of these become visible on the clock edge after the request is sampled.
- R4: For exc_kind=0 (general), excvaddr_o takes exc_vaddr only when exc_addr_valid is 1. Otherwise it keeps its value.
- R5: A debug request is taken only when the status interrupt-level field is strictly below DBG_LEVEL. Otherwise it has no effect on any output.
- R6: On debug entry, dbgcause_o takes dbg_cause, dbg_epc_o takes exc_pc and dbg_eps_o takes the whole old status word. The interrupt-level field becomes DBG_LEVEL, the exception-mode bit is set, and vec_sel=3 (DEBUG).
- R7: exc_kind=1 (misaligned) writes ALIGN_CAUSE and loads exc_vaddr into excvaddr_o only when UNALIGNED_EXC=1 and HW_ALIGN=0. Otherwise the request is ignored.
- R8: exc_kind=2 (fetch bus error) writes FETCH_CAUSE and loads exc_pc into excvaddr_o. exc_kind=3 (load/store bus error) writes DATA_CAUSE and loads exc_vaddr into excvaddr_o.
- R9: When a taken debug request and a general exception arrive in the same cycle, the debug entry is performed and the general exception is dropped. exccause_o is left unchanged.
- R10: sts_wr loads sts_wdata into the status word when no exception or debug entry is taken in that cycle. A taken entry overrides the load.
- R11: After reset, all registers read 0 and vec_valid is 0.

Status-word layout at the defaults: interrupt level in bits [3:0], exception-mode bit 4, user-mode bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | General exception request |
| exc_kind | input | 2 | 0 general, 1 misaligned, 2 fetch bus error, 3 load/store bus error |
| exc_cause | input | CW | Cause code for kind 0 |
| exc_pc | input | AW | Faulting PC, also used for debug entry |
| exc_vaddr | input | AW | Faulting data virtual address |
| exc_addr_valid | input | 1 | Kind 0 carries a valid address |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | DCW | Debug cause bits |
| sts_wr | input | 1 | Status word load strobe |
| sts_wdata | input | SW | Status word load value |
| vec_valid | output | 1 | One-cycle dispatch pulse |
| vec_sel | output | 2 | 0 user, 1 kernel, 2 double, 3 debug |
| status_o | output | SW | Status word |
| epc1_o | output | AW | Level-1 saved PC |
| depc_o | output | AW | Double-exception saved PC |
| exccause_o | output | CW | Exception cause |
| excvaddr_o | output | AW | Exception virtual address |
| dbgcause_o | output | DCW | Debug cause |
| dbg_epc_o | output | AW | Saved PC for the debug level |
| dbg_eps_o | output | SW | Saved status for the debug level |

## Verification
The bench builds two instances that share their inputs. u0 uses the defaults: a dedicated double-exception PC register, misaligned traps enabled and a debug level of 6. The whole scoreboard runs against u0, so it covers nesting, the debug gate at levels 3, 6 and 7, and every priority case. u1 is built with HAS_DEPC=0 and HW_ALIGN=1. It makes the other two variants reachable: a nested PC that lands in the level-1 register, and a misaligned request that has no effect.

// File: rtl/exc_pkg.sv
package exc_pkg;

   typedef enum logic [1:0] {
      VEC_USER   = 2'd0,
      VEC_KERNEL = 2'd1,
      VEC_DOUBLE = 2'd2,
      VEC_DEBUG  = 2'd3
   } vec_e;

   typedef enum logic [1:0] {
      KIND_GENERAL   = 2'd0,
      KIND_MISALIGN  = 2'd1,
      KIND_FETCH_BUS = 2'd2,
      KIND_DATA_BUS  = 2'd3
   } kind_e;

endpackage

// File: rtl/exc_cause_map.sv
module exc_cause_map
   import exc_pkg::*;
#(
   parameter int AW            = 32,
   parameter int CW            = 6,
   parameter int ALIGN_CAUSE   = 9,
   parameter int FETCH_CAUSE   = 12,
   parameter int DATA_CAUSE    = 13,
   parameter bit UNALIGNED_EXC = 1'b1,
   parameter bit HW_ALIGN      = 1'b0
) (
   input  logic          req,
   input  logic [1:0]    kind,
   input  logic [CW-1:0] cause_in,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] vaddr,
   input  logic          addr_valid,
   output logic          take,
   output logic [CW-1:0] cause_out,
   output logic          addr_wr,
   output logic [AW-1:0] addr_out
);

   localparam logic [CW-1:0] ALIGN_C = CW'(ALIGN_CAUSE);
   localparam logic [CW-1:0] FETCH_C = CW'(FETCH_CAUSE);
   localparam logic [CW-1:0] DATA_C  = CW'(DATA_CAUSE);

   initial begin
      assert (ALIGN_CAUSE < (1 << CW) && FETCH_CAUSE < (1 << CW) && DATA_CAUSE < (1 << CW))
         else $error("exc_cause_map: a fixed cause code does not fit in CW bits");
   end

   logic align_on;

   generate
      if (UNALIGNED_EXC && !HW_ALIGN) begin : g_align_trap
         assign align_on = 1'b1;
      end else begin : g_align_quiet
         assign align_on = 1'b0;
      end
   endgenerate

   always_comb begin
      take      = 1'b0;
      cause_out = cause_in;
      addr_wr   = 1'b0;
      addr_out  = vaddr;
      if (req) begin
         unique case (kind_e'(kind))
            KIND_GENERAL: begin
               take    = 1'b1;
               addr_wr = addr_valid;
            end
            KIND_MISALIGN: begin
               take      = align_on;
               cause_out = ALIGN_C;
               addr_wr   = align_on;
            end
            KIND_FETCH_BUS: begin
               take      = 1'b1;
               cause_out = FETCH_C;
               addr_wr   = 1'b1;
               addr_out  = pc;
            end
            KIND_DATA_BUS: begin
               take      = 1'b1;
               cause_out = DATA_C;
               addr_wr   = 1'b1;
            end
            default: take = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
   import exc_pkg::*;
#(
   parameter int SW       = 16,
   parameter int EXCM_BIT = 4,
   parameter int UM_BIT   = 5
) (
   input  logic [SW-1:0] status,
   output logic          nested,
   output logic [1:0]    vec
);

   initial begin
      assert (EXCM_BIT < SW && UM_BIT < SW && EXCM_BIT != UM_BIT)
         else $error("exc_vector_sel: status bit positions invalid");
   end

   always_comb begin
      nested = status[EXCM_BIT];
      if (nested)
         vec = VEC_DOUBLE;
      else if (status[UM_BIT])
         vec = VEC_USER;
      else
         vec = VEC_KERNEL;
   end

endmodule

// File: rtl/exc_dbg_gate.sv
module exc_dbg_gate #(
   parameter int ILW       = 4,
   parameter int DBG_LEVEL = 6
) (
   input  logic           req,
   input  logic [ILW-1:0] intlevel,
   output logic           take
);

   localparam logic [ILW-1:0] LVL = ILW'(DBG_LEVEL);

   initial begin
      assert (DBG_LEVEL >= 2 && DBG_LEVEL < (1 << ILW))
         else $error("exc_dbg_gate: DBG_LEVEL outside the interrupt-level range");
   end

   assign take = req && (intlevel < LVL);

endmodule

// File: rtl/exc_dispatch_ctrl.sv
module exc_dispatch_ctrl
   import exc_pkg::*;
#(
   parameter int AW            = 32,
   parameter int CW            = 6,
   parameter int DCW           = 6,
   parameter int SW            = 16,
   parameter int IL_LSB        = 0,
   parameter int IL_W          = 4,
   parameter int EXCM_BIT      = 4,
   parameter int UM_BIT        = 5,
   parameter int DBG_LEVEL     = 6,
   parameter bit HAS_DEPC      = 1'b1,
   parameter bit UNALIGNED_EXC = 1'b1,
   parameter bit HW_ALIGN      = 1'b0,
   parameter int ALIGN_CAUSE   = 9,
   parameter int FETCH_CAUSE   = 12,
   parameter int DATA_CAUSE    = 13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           exc_req,
   input  logic [1:0]     exc_kind,
   input  logic [CW-1:0]  exc_cause,
   input  logic [AW-1:0]  exc_pc,
   input  logic [AW-1:0]  exc_vaddr,
   input  logic           exc_addr_valid,
   input  logic           dbg_req,
   input  logic [DCW-1:0] dbg_cause,
   input  logic           sts_wr,
   input  logic [SW-1:0]  sts_wdata,
   output logic           vec_valid,
   output logic [1:0]     vec_sel,
   output logic [SW-1:0]  status_o,
   output logic [AW-1:0]  epc1_o,
   output logic [AW-1:0]  depc_o,
   output logic [CW-1:0]  exccause_o,
   output logic [AW-1:0]  excvaddr_o,
   output logic [DCW-1:0] dbgcause_o,
   output logic [AW-1:0]  dbg_epc_o,
   output logic [SW-1:0]  dbg_eps_o
);

   localparam int IL_MSB = IL_LSB + IL_W - 1;
   localparam logic [IL_W-1:0] DBG_LVL = IL_W'(DBG_LEVEL);

   initial begin
      assert (IL_MSB < SW) else $error("exc_dispatch_ctrl: level field exceeds status width");
      assert ((EXCM_BIT < IL_LSB || EXCM_BIT > IL_MSB) && (UM_BIT < IL_LSB || UM_BIT > IL_MSB))
         else $error("exc_dispatch_ctrl: mode bits overlap the level field");
   end

   logic [SW-1:0]   status_q;
   logic [IL_W-1:0] cur_level;
   logic            dbg_take;
   logic            gen_hit;
   logic            gen_go;
   logic [CW-1:0]   gen_cause;
   logic            gen_addr_wr;
   logic [AW-1:0]   gen_addr;
   logic            nested;
   logic [1:0]      gen_vec;
   logic            epc1_we;
   logic [SW-1:0]   dbg_status;
   logic [SW-1:0]   gen_status;

   assign cur_level = status_q[IL_MSB:IL_LSB];

   exc_dbg_gate #(
      .ILW       (IL_W),
      .DBG_LEVEL (DBG_LEVEL)
   ) u_gate (
      .req      (dbg_req),
      .intlevel (cur_level),
      .take     (dbg_take)
   );

   exc_cause_map #(
      .AW            (AW),
      .CW            (CW),
      .ALIGN_CAUSE   (ALIGN_CAUSE),
      .FETCH_CAUSE   (FETCH_CAUSE),
      .DATA_CAUSE    (DATA_CAUSE),
      .UNALIGNED_EXC (UNALIGNED_EXC),
      .HW_ALIGN      (HW_ALIGN)
   ) u_cmap (
      .req        (exc_req),
      .kind       (exc_kind),
      .cause_in   (exc_cause),
      .pc         (exc_pc),
      .vaddr      (exc_vaddr),
      .addr_valid (exc_addr_valid),
      .take       (gen_hit),
      .cause_out  (gen_cause),
      .addr_wr    (gen_addr_wr),
      .addr_out   (gen_addr)
   );

   exc_vector_sel #(
      .SW       (SW),
      .EXCM_BIT (EXCM_BIT),
      .UM_BIT   (UM_BIT)
   ) u_vsel (
      .status (status_q),
      .nested (nested),
      .vec    (gen_vec)
   );

   // debug entry outranks a general exception in the same cycle
   assign gen_go = gen_hit && !dbg_take;

   always_comb begin
      dbg_status                 = status_q;
      dbg_status[IL_MSB:IL_LSB]  = DBG_LVL;
      dbg_status[EXCM_BIT]       = 1'b1;
      gen_status                 = status_q;
      gen_status[EXCM_BIT]       = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q   <= '0;
         vec_valid  <= 1'b0;
         vec_sel    <= VEC_USER;
         exccause_o <= '0;
         excvaddr_o <= '0;
         dbgcause_o <= '0;
         dbg_epc_o  <= '0;
         dbg_eps_o  <= '0;
      end else begin
         vec_valid <= 1'b0;
         if (dbg_take) begin
            dbgcause_o <= dbg_cause;
            dbg_epc_o  <= exc_pc;
            dbg_eps_o  <= status_q;
            status_q   <= dbg_status;
            vec_valid  <= 1'b1;
            vec_sel    <= VEC_DEBUG;
         end else if (gen_go) begin
            exccause_o <= gen_cause;
            if (gen_addr_wr)
               excvaddr_o <= gen_addr;
            status_q  <= gen_status;
            vec_valid <= 1'b1;
            vec_sel   <= gen_vec;
         end else if (sts_wr) begin
            status_q <= sts_wdata;
         end
      end
   end

   generate
      if (HAS_DEPC) begin : g_depc
         logic [AW-1:0] depc_q;
         assign epc1_we = gen_go && !nested;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               depc_q <= '0;
            else if (gen_go && nested)
               depc_q <= exc_pc;
         end
         assign depc_o = depc_q;
      end else begin : g_no_depc
         assign epc1_we = gen_go;
         assign depc_o  = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         epc1_o <= '0;
      else if (epc1_we)
         epc1_o <= exc_pc;
   end

   assign status_o = status_q;

   // ---------------- assertions ----------------
   AST_EXCM_ON_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> status_q[EXCM_BIT]); // R3

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid && !$past(exc_req) && !$past(dbg_req) |-> 1'b0); // R3

   AST_DOUBLE_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid && vec_sel == VEC_DOUBLE |-> $past(status_q[EXCM_BIT])); // R1

   AST_USER_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid && vec_sel == VEC_USER |-> $past(status_q[UM_BIT]) && !$past(status_q[EXCM_BIT])); // R2

   AST_DBG_BELOW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid && vec_sel == VEC_DEBUG |-> $past(cur_level) < DBG_LVL); // R5

   AST_DBG_RAISES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid && vec_sel == VEC_DEBUG |-> cur_level == DBG_LVL && dbg_eps_o == $past(status_q)); // R6

   AST_DBG_KEEPS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid && vec_sel == VEC_DEBUG |-> $stable(exccause_o)); // R9

endmodule

// File: tb/sim_exc_dispatch_ctrl.sv
module sim_exc_dispatch_ctrl;

   localparam int AW = 32;
   localparam int CW = 6;
   localparam int DCW = 6;
   localparam int SW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic           exc_req = 0;
   logic [1:0]     exc_kind = 0;
   logic [CW-1:0]  exc_cause = 0;
   logic [AW-1:0]  exc_pc = 0;
   logic [AW-1:0]  exc_vaddr = 0;
   logic           exc_addr_valid = 0;
   logic           dbg_req = 0;
   logic [DCW-1:0] dbg_cause = 0;
   logic           sts_wr = 0;
   logic [SW-1:0]  sts_wdata = 0;

   logic           vv0, vv1;
   logic [1:0]     vs0, vs1;
   logic [SW-1:0]  st0, st1;
   logic [AW-1:0]  e10, e11, d0, d1;
   logic [CW-1:0]  c0, c1;
   logic [AW-1:0]  va0, va1;
   logic [DCW-1:0] dc0, dc1;
   logic [AW-1:0]  de0, de1;
   logic [SW-1:0]  ds0, ds1;

   exc_dispatch_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_kind(exc_kind),
      .exc_cause(exc_cause), .exc_pc(exc_pc), .exc_vaddr(exc_vaddr),
      .exc_addr_valid(exc_addr_valid), .dbg_req(dbg_req), .dbg_cause(dbg_cause),
      .sts_wr(sts_wr), .sts_wdata(sts_wdata), .vec_valid(vv0), .vec_sel(vs0),
      .status_o(st0), .epc1_o(e10), .depc_o(d0), .exccause_o(c0),
      .excvaddr_o(va0), .dbgcause_o(dc0), .dbg_epc_o(de0), .dbg_eps_o(ds0));

   exc_dispatch_ctrl #(.HAS_DEPC(1'b0), .HW_ALIGN(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_kind(exc_kind),
      .exc_cause(exc_cause), .exc_pc(exc_pc), .exc_vaddr(exc_vaddr),
      .exc_addr_valid(exc_addr_valid), .dbg_req(dbg_req), .dbg_cause(dbg_cause),
      .sts_wr(sts_wr), .sts_wdata(sts_wdata), .vec_valid(vv1), .vec_sel(vs1),
      .status_o(st1), .epc1_o(e11), .depc_o(d1), .exccause_o(c1),
      .excvaddr_o(va1), .dbgcause_o(dc1), .dbg_epc_o(de1), .dbg_eps_o(ds1));

   typedef struct {
      int             due;
      string          tag;
      logic           vv;
      logic [1:0]     vs;
      logic [SW-1:0]  st;
      logic [AW-1:0]  e1;
      logic [AW-1:0]  dp;
      logic [CW-1:0]  cs;
      logic [AW-1:0]  va;
      logic [DCW-1:0] dc;
      logic [AW-1:0]  de;
      logic [SW-1:0]  ds;
   } item_t;

   item_t q[$];
   int cyc = 0;
   int checks = 0;
   int errors = 0;

   // bench model of u0 (defaults: level 6, EXCM bit 4, UM bit 5, causes 9/12/13)
   logic [SW-1:0]  m_st = 0;
   logic [AW-1:0]  m_e1 = 0, m_dp = 0, m_va = 0, m_de = 0;
   logic [CW-1:0]  m_cs = 0;
   logic [DCW-1:0] m_dc = 0;
   logic [SW-1:0]  m_ds = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due == cyc) begin
         item_t it;
         it = q.pop_front();
         chk(it.tag, "vec_valid", 64'(vv0), 64'(it.vv));
         if (it.vv) chk(it.tag, "vec_sel", 64'(vs0), 64'(it.vs));
         chk(it.tag, "status", 64'(st0), 64'(it.st));
         chk(it.tag, "epc1", 64'(e10), 64'(it.e1));
         chk(it.tag, "depc", 64'(d0), 64'(it.dp));
         chk(it.tag, "exccause", 64'(c0), 64'(it.cs));
         chk(it.tag, "excvaddr", 64'(va0), 64'(it.va));
         chk(it.tag, "dbgcause", 64'(dc0), 64'(it.dc));
         chk(it.tag, "dbg_epc", 64'(de0), 64'(it.de));
         chk(it.tag, "dbg_eps", 64'(ds0), 64'(it.ds));
      end
   end

   task automatic step(input string tag, input logic er, input logic [1:0] kd,
                       input logic [CW-1:0] cs, input logic [AW-1:0] pc,
                       input logic [AW-1:0] va, input logic av, input logic dr,
                       input logic [DCW-1:0] dc, input logic sw, input logic [SW-1:0] swd);
      item_t it;
      logic dtake, gtake;
      logic [1:0] vs;
      exc_req = er; exc_kind = kd; exc_cause = cs; exc_pc = pc; exc_vaddr = va;
      exc_addr_valid = av; dbg_req = dr; dbg_cause = dc; sts_wr = sw; sts_wdata = swd;
      dtake = dr && (m_st[3:0] < 4'd6);
      gtake = er;
      vs = 2'd0;
      if (dtake) begin
         m_dc = dc; m_de = pc; m_ds = m_st;
         m_st = {m_st[15:5], 1'b1, 4'd6};
         vs = 2'd3;
      end else if (gtake) begin
         if (m_st[4]) begin m_dp = pc; vs = 2'd2; end
         else begin m_e1 = pc; vs = m_st[5] ? 2'd0 : 2'd1; end
         case (kd)
            2'd0: begin m_cs = cs; if (av) m_va = va; end
            2'd1: begin m_cs = 6'd9; m_va = va; end
            2'd2: begin m_cs = 6'd12; m_va = pc; end
            default: begin m_cs = 6'd13; m_va = va; end
         endcase
         m_st[4] = 1'b1;
      end else if (sw) begin
         m_st = swd;
      end
      it.due = cyc + 1; it.tag = tag; it.vv = dtake || gtake; it.vs = vs;
      it.st = m_st; it.e1 = m_e1; it.dp = m_dp; it.cs = m_cs; it.va = m_va;
      it.dc = m_dc; it.de = m_de; it.ds = m_ds;
      q.push_back(it);
      @(negedge clk);
      exc_req = 0; dbg_req = 0; sts_wr = 0; exc_addr_valid = 0;
   endtask

   task automatic setst(input string tag, input logic [SW-1:0] v);
      step(tag, 0, 2'd0, 0, 0, 0, 0, 0, 0, 1, v);
   endtask

   initial begin
      #(10 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk("R11", "vec_valid", 64'(vv0), 64'd0);
      chk("R11", "status", 64'(st0), 64'd0);
      chk("R11", "epc1", 64'(e10), 64'd0);
      chk("R11", "depc", 64'(d0), 64'd0);
      chk("R11", "dbg_eps", 64'(ds0), 64'd0);

      // R2 R3 R4: kernel entry with address
      step("R2_R3_R4", 1, 2'd0, 6'd5, 32'h100, 32'hAAA, 1, 0, 0, 0, 0);
      step("R3_pulse", 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
      // R1 nested, no address (R4 keeps vaddr)
      step("R1_R4", 1, 2'd0, 6'd7, 32'h200, 32'hBBB, 0, 0, 0, 0, 0);
      chk("R1", "u1 epc1", 64'(e11), 64'h200);
      chk("R1", "u1 depc", 64'(d1), 64'd0);
      // R2 user vector, R7 misalign
      setst("R10", 16'h0020);
      step("R2_R7", 1, 2'd1, 6'd0, 32'h300, 32'h303, 0, 0, 0, 0, 0);
      chk("R7", "u1 vec_valid", 64'(vv1), 64'd0);
      chk("R7", "u1 exccause", 64'(c1), 64'd7);
      // R8 bus errors
      setst("R10", 16'h0000);
      step("R8_data", 1, 2'd3, 6'd0, 32'h400, 32'h4F0, 0, 0, 0, 0, 0);
      setst("R10", 16'h0000);
      step("R8_fetch", 1, 2'd2, 6'd0, 32'h500, 32'h999, 0, 0, 0, 0, 0);
      // R6 debug entry below level
      setst("R10", 16'h0003);
      step("R6", 0, 2'd0, 0, 32'h600, 0, 0, 1, 6'h2, 0, 0);
      // R5 gated at level 7 and at level 6
      setst("R10", 16'h0007);
      step("R5_lvl7", 0, 2'd0, 0, 32'h610, 0, 0, 1, 6'h3, 0, 0);
      setst("R10", 16'h0006);
      step("R5_lvl6", 0, 2'd0, 0, 32'h620, 0, 0, 1, 6'h4, 0, 0);
      // R9 both in same cycle, debug wins
      setst("R10", 16'h0005);
      step("R9", 1, 2'd0, 6'd21, 32'h700, 32'h777, 1, 1, 6'h8, 0, 0);
      // R9/R5 both, debug gated -> general taken
      setst("R10", 16'h0007);
      step("R9_gated", 1, 2'd0, 6'd22, 32'h800, 32'h888, 1, 1, 6'h9, 0, 0);
      // R10 exception overrides status load
      setst("R10", 16'h0000);
      step("R10_override", 1, 2'd0, 6'd23, 32'h900, 0, 0, 0, 0, 1, 16'h0020);
      step("R3_idle", 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0);
      repeat (2) @(negedge clk);
      chk("R3", "queue drained", 64'(q.size()), 64'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule